// File: doc/BRIEF.md
# Packet-command PIO transfer sequencer

This block is the device-side sequencer for a storage device that carries its commands as 12-byte packets. The host writes the packet command code to the command register. The device then collects the 12-byte command packet as six 16-bit writes to the data register. When the packet holds a block read, the device returns the requested data through the data register in programmed I/O mode. The host sets a byte count limit before the command. The data phase is cut into bursts no larger than that limit. Each burst opens with an interrupt, and a final interrupt marks completion.

The media is an external word source. The block presents the decoded start block address and a running word index, and the source answers on the same cycle with the word at that position. If the host sets bit 0 of the feature register before the command, the data phase is handed to an external DMA engine instead: the block pulses a start strobe and waits for a done strobe. The limit register pair also reads back the byte count of the current burst, so the host knows how many bytes to read.

Top module: `pio_packet_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x0040, the interrupt output is low, the DMA start strobe is low, and both byte count registers (addresses 4 and 5) read 0.
- R2: Writing 0xA0 to address 7 while idle makes status read 0x00C0 (busy, ready) for one cycle. Status then reads 0x0048 (data request, ready) while the packet is collected. Any other command value while idle is ignored: status stays 0x0040 and no interrupt is raised.
- R3: The packet is six writes to address 0. Write k supplies packet byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. The sixth write ends the packet phase, and status reads 0x00C0 for one decode cycle.
- R4: For a block read (packet byte 0 equal to 0x28), the start block is bytes 2..5 taken big-endian and presented on media_lba. The block count is bytes 7..8 taken big-endian, and each block is 2048 bytes. Data read n of the transfer returns media_data while media_idx equals n.
- R5: Each burst carries min(remaining, limit) bytes, except that an odd limit is rounded down to even unless the remaining length is below the limit. The limit is the value of addresses 5:4 (high:low byte) at command time.
- R6: During a burst, addresses 4 and 5 read the low and high byte of that burst's byte count.
- R7: Before each burst the interrupt is raised, and status reads 0x0048 while the burst's words are read.
- R8: Reading the last word of the last burst raises the completion interrupt, and status then reads 0x0040.
- R9: A status read clears the interrupt. If it falls on the cycle in which an interrupt is raised, the interrupt stays set.
- R10: A data read while data request is clear returns 0 and does not advance the word index.
- R11: With feature bit 0 set, a valid read with a nonzero count gives a one-cycle DMA start pulse and status 0x0048. There is no interrupt until dma_done, which then raises the completion interrupt and returns status to 0x0040.
- R12: A packet opcode other than 0x28, or a PIO-mode limit below 2, aborts the command. Status reads 0x0041, the error register (address 1) reads 0x0004, and the interrupt is raised.
- R13: A block read with count 0 completes at once with the interrupt and status 0x0040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (read side effects apply at the clock edge) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 16 | Write data (byte registers use bits 7:0) |
| host_rdata | output | 16 | Read data for host_addr |
| intrq | output | 1 | Interrupt request to the host |
| media_lba | output | 32 | Start block of the current read |
| media_idx | output | 26 | Word index within the transfer |
| media_data | input | 16 | Word at media_idx from the media source |
| dma_start | output | 1 | One-cycle strobe starting a DMA data phase |
| dma_done | input | 1 | DMA data phase finished |

## Verification
The case that matters is a status read and an interrupt raise landing in the same cycle. This happens when the host polls status in the busy cycle that arms the next burst, right after the last word of the previous burst. The bench issues a status read exactly on that cycle. It expects the busy value to be read back and the interrupt to remain high afterwards. On other burst boundaries it issues a data read in that cycle instead, and checks that the read returns 0 and that the following word still carries the expected index.

// File: rtl/pps_pkg.sv
// Shared encodings for the packet PIO sequencer: status bits, register
// addresses and the sequencer state type. Assumes a byte-wide register view.
package pps_pkg;
    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_ERR  = 8'h01;
    localparam logic [7:0] ER_ABORT = 8'h04;

    localparam logic [2:0] RA_DATA = 3'd0;
    localparam logic [2:0] RA_FEAT = 3'd1;
    localparam logic [2:0] RA_BCLO = 3'd4;
    localparam logic [2:0] RA_BCHI = 3'd5;
    localparam logic [2:0] RA_CMD  = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE, S_CMDBSY, S_PKT, S_DECODE, S_ARM, S_XFER, S_DMA
    } seq_state_t;
endpackage

// File: rtl/pps_pktbuf.sv
// Command packet collector. Gathers PKT_WORDS 16-bit writes into a byte
// array (low byte first) and decodes the read opcode, start block and count.
// Assumes PKT_WORDS >= 5 so that bytes 0..8 exist.
module pps_pktbuf #(
    parameter int PKT_WORDS = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic        last_word,
    output logic [7:0]  opcode,
    output logic [31:0] lba,
    output logic [15:0] nblk
);
    localparam int NBYTES = 2 * PKT_WORDS;
    localparam int CW     = $clog2(PKT_WORDS);

    logic [CW-1:0] cnt_q;
    logic [7:0]    byte_q [NBYTES];

    assign last_word = (cnt_q == CW'(PKT_WORDS - 1));

    // Word position within the packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (wr)       cnt_q <= last_word ? '0 : cnt_q + 1'b1;
    end

    // Byte storage, one word slot per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) byte_q[i] <= '0;
        end else if (wr) begin
            for (int k = 0; k < PKT_WORDS; k++) begin
                if (cnt_q == CW'(k)) begin
                    byte_q[2*k]   <= wdata[7:0];
                    byte_q[2*k+1] <= wdata[15:8];
                end
            end
        end
    end

    assign opcode = byte_q[0];
    assign lba    = {byte_q[2], byte_q[3], byte_q[4], byte_q[5]};
    assign nblk   = {byte_q[7], byte_q[8]};

    a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(PKT_WORDS));
endmodule

// File: rtl/pps_hostregs.sv
// Host-visible byte registers: DMA select (feature bit 0), byte count
// limit pair with burst write-back, and the abort flag. Host writes are
// pre-qualified by the sequencer; write-back has priority over the host.
module pps_hostregs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_feat,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [7:0]  wbyte,
    input  logic        wb_en,
    input  logic [15:0] wb_val,
    input  logic        set_abort,
    input  logic        clr_abort,
    output logic        dma_sel,
    output logic [15:0] bc_q,
    output logic        abort_q
);
    // DMA path select.
    always_ff @(posedge clk) begin
        if (!rst_n)       dma_sel <= 1'b0;
        else if (wr_feat) dma_sel <= wbyte[0];
    end

    // Byte count pair: limit from host, burst count from the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)      bc_q <= '0;
        else if (wb_en)  bc_q <= wb_val;
        else if (wr_lo)  bc_q[7:0]  <= wbyte;
        else if (wr_hi)  bc_q[15:8] <= wbyte;
    end

    // Abort flag shown in status and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n)         abort_q <= 1'b0;
        else if (set_abort) abort_q <= 1'b1;
        else if (clr_abort) abort_q <= 1'b0;
    end
endmodule

// File: rtl/pps_burst.sv
// Remaining-length tracker and burst sizer. Loads the transfer length at
// decode, sizes each burst against the captured limit, counts words of the
// current burst and the word index of the whole transfer.
// Assumes the limit is at least 2 when a burst is armed.
module pps_burst #(
    parameter int BLK_BYTES = 2048,
    parameter int CNT_W     = 16,
    parameter int LIM_W     = 16,
    localparam int BLK_SH   = $clog2(BLK_BYTES),
    localparam int REM_W    = CNT_W + BLK_SH,
    localparam int IDX_W    = REM_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] nblk,
    input  logic [LIM_W-1:0] lim,
    input  logic             arm,
    input  logic             pop,
    output logic [LIM_W-1:0] burst_bytes,
    output logic             last_word,
    output logic             rem_zero,
    output logic [IDX_W-1:0] idx
);
    logic [REM_W-1:0] rem_q;
    logic [LIM_W-1:0] lim_q;
    logic [LIM_W-1:0] wcnt_q;
    logic [LIM_W:0]   words_w;

    assign burst_bytes = (rem_q < REM_W'(lim_q)) ? rem_q[LIM_W-1:0]
                                                 : {lim_q[LIM_W-1:1], 1'b0};
    assign words_w   = ({1'b0, burst_bytes} + (LIM_W+1)'(1)) >> 1;
    assign last_word = (wcnt_q == LIM_W'(1));
    assign rem_zero  = (rem_q == '0);

    // Remaining bytes and captured limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            rem_q <= REM_W'(nblk) << BLK_SH;
            lim_q <= lim;
        end else if (arm) begin
            rem_q <= rem_q - REM_W'(burst_bytes);
        end
    end

    // Words left in the burst and transfer word index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            idx    <= '0;
        end else if (load) begin
            wcnt_q <= '0;
            idx    <= '0;
        end else if (arm) begin
            wcnt_q <= words_w[LIM_W-1:0];
        end else if (pop) begin
            wcnt_q <= wcnt_q - 1'b1;
            idx    <= idx + 1'b1;
        end
    end

    a_r5_burst_in_limit: assert property (@(posedge clk) disable iff (!rst_n)
        arm |-> (burst_bytes <= lim_q) && (burst_bytes != '0));
endmodule

// File: rtl/pio_packet_seq.sv
// Packet-command PIO sequencer top. Accepts the packet command, collects the
// command packet, decodes a block read and runs the data phase either as
// interrupt-gated PIO bursts or through an external DMA engine.
// Assumes one host access per cycle; read side effects apply at the edge.
module pio_packet_seq #(
    parameter int         BLK_BYTES = 2048,
    parameter int         PKT_WORDS = 6,
    parameter logic [7:0] PKT_CMD   = 8'hA0,
    parameter logic [7:0] READ_OP   = 8'h28,
    localparam int CNT_W = 16,
    localparam int LIM_W = 16,
    localparam int IDX_W = CNT_W + $clog2(BLK_BYTES) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [2:0]       host_addr,
    input  logic [15:0]      host_wdata,
    output logic [15:0]      host_rdata,
    output logic             intrq,
    output logic [31:0]      media_lba,
    output logic [IDX_W-1:0] media_idx,
    input  logic [15:0]      media_data,
    output logic             dma_start,
    input  logic             dma_done
);
    import pps_pkg::*;

    seq_state_t st_q, st_d;
    logic acc_cmd, pkt_wr, pop, stat_rd, in_idle, bsy, drq;
    logic pkt_last, burst_last, rem_zero, dma_sel, abort_q;
    logic bad, zero_len, intr_set;
    logic [7:0]       opcode;
    logic [CNT_W-1:0] nblk;
    logic [LIM_W-1:0] bc_q, burst_bytes;
    logic [7:0]       status;

    assign in_idle = (st_q == S_IDLE);
    assign bsy     = (st_q == S_CMDBSY) || (st_q == S_DECODE) || (st_q == S_ARM);
    assign drq     = (st_q == S_PKT) || (st_q == S_XFER) || (st_q == S_DMA);
    assign acc_cmd = host_wr && in_idle && (host_addr == RA_CMD) && (host_wdata[7:0] == PKT_CMD);
    assign pkt_wr  = host_wr && (st_q == S_PKT) && (host_addr == RA_DATA);
    assign pop     = host_rd && (st_q == S_XFER) && (host_addr == RA_DATA);
    assign stat_rd = host_rd && (host_addr == RA_CMD);
    assign bad      = (opcode != READ_OP) || (!dma_sel && (bc_q < LIM_W'(2)));
    assign zero_len = (nblk == '0);

    pps_pktbuf #(.PKT_WORDS(PKT_WORDS)) u_pkt (
        .clk(clk), .rst_n(rst_n), .clr(acc_cmd), .wr(pkt_wr),
        .wdata(host_wdata), .last_word(pkt_last), .opcode(opcode),
        .lba(media_lba), .nblk(nblk)
    );

    pps_hostregs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_feat(host_wr && in_idle && (host_addr == RA_FEAT)),
        .wr_lo(host_wr && in_idle && (host_addr == RA_BCLO)),
        .wr_hi(host_wr && in_idle && (host_addr == RA_BCHI)),
        .wbyte(host_wdata[7:0]),
        .wb_en(st_q == S_ARM), .wb_val(burst_bytes),
        .set_abort((st_q == S_DECODE) && bad), .clr_abort(acc_cmd),
        .dma_sel(dma_sel), .bc_q(bc_q), .abort_q(abort_q)
    );

    pps_burst #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W), .LIM_W(LIM_W)) u_burst (
        .clk(clk), .rst_n(rst_n),
        .load(st_q == S_DECODE), .nblk(nblk), .lim(bc_q),
        .arm(st_q == S_ARM), .pop(pop),
        .burst_bytes(burst_bytes), .last_word(burst_last),
        .rem_zero(rem_zero), .idx(media_idx)
    );

    // Next-state selection for the command sequence.
    always_comb begin
        st_d = st_q;
        case (st_q)
            S_IDLE:   if (acc_cmd) st_d = S_CMDBSY;
            S_CMDBSY: st_d = S_PKT;
            S_PKT:    if (pkt_wr && pkt_last) st_d = S_DECODE;
            S_DECODE: begin
                if (bad || zero_len) st_d = S_IDLE;
                else if (dma_sel)    st_d = S_DMA;
                else                 st_d = S_ARM;
            end
            S_ARM:    st_d = S_XFER;
            S_XFER:   if (pop && burst_last) st_d = rem_zero ? S_IDLE : S_ARM;
            S_DMA:    if (dma_done) st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    assign intr_set = ((st_q == S_DECODE) && (bad || zero_len))
                    || (st_q == S_ARM)
                    || (pop && burst_last && rem_zero)
                    || ((st_q == S_DMA) && dma_done);

    // Interrupt line: raise wins over a clearing status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  intrq <= 1'b0;
        else if (intr_set)           intrq <= 1'b1;
        else if (stat_rd || acc_cmd) intrq <= 1'b0;
    end

    // One-cycle DMA start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) dma_start <= 1'b0;
        else        dma_start <= (st_q == S_DECODE) && !bad && !zero_len && dma_sel;
    end

    assign status = (bsy ? ST_BSY : 8'h00) | ST_DRDY | (drq ? ST_DRQ : 8'h00)
                  | (abort_q ? ST_ERR : 8'h00);

    // Host read data selection.
    always_comb begin
        case (host_addr)
            RA_DATA: host_rdata = (st_q == S_XFER) ? media_data : 16'h0000;
            RA_FEAT: host_rdata = {8'h00, abort_q ? ER_ABORT : 8'h00};
            RA_BCLO: host_rdata = {8'h00, bc_q[7:0]};
            RA_BCHI: host_rdata = {8'h00, bc_q[15:8]};
            RA_CMD:  host_rdata = {8'h00, status};
            default: host_rdata = 16'h0000;
        endcase
    end

    a_r9_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !intr_set) |=> !intrq);
    a_r9_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        intr_set |=> intrq);
    a_r10_idle_read_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_addr == RA_DATA) && (st_q != S_XFER) && (st_q != S_DECODE))
        |=> $stable(media_idx));
    a_r8_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && burst_last && rem_zero) |=> (st_q == S_IDLE) && intrq);
    a_r11_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |=> !dma_start);
endmodule

// File: tb/sim_pio_packet_seq.sv
module sim_pio_packet_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        intrq;
    logic [31:0] media_lba;
    logic [25:0] media_idx;
    logic [15:0] media_data;
    logic        dma_start;
    logic        dma_done = 1'b0;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] mix(input logic [31:0] l, input logic [25:0] i);
        return l[15:0] ^ l[31:16] ^ (i[15:0] * 16'h9E37) ^ {6'b0, i[25:16]};
    endfunction

    assign media_data = mix(media_lba, media_idx);

    pio_packet_seq u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .intrq(intrq), .media_lba(media_lba), .media_idx(media_idx),
        .media_data(media_data), .dma_start(dma_start), .dma_done(dma_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Tasks are entered at a falling edge and return at the next one.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_intr(input string tag);
        int k = 0;
        while (!intrq && k < 100) begin
            @(negedge clk);
            k++;
        end
        check(tag, {31'b0, intrq}, 32'd1);
    endtask

    function automatic int exp_burst(input int total, input int lim);
        return (total < lim) ? total : (lim & 32'hFFFE);
    endfunction

    task automatic xact(input logic [7:0] op, input logic [31:0] lba, input int nblk,
                        input logic [15:0] lim, input bit dma, input bit collide);
        logic [15:0] d;
        logic [7:0]  b [12];
        int total, idx, burst;
        bit bad;
        wr(3'd1, {15'b0, dma});
        wr(3'd4, {8'h00, lim[7:0]});
        wr(3'd5, {8'h00, lim[15:8]});
        wr(3'd7, 16'h00A0);
        rd(3'd7, d); check("R2 busy after command", d, 32'h00C0);
        rd(3'd7, d); check("R2 packet phase status", d, 32'h0048);
        for (int i = 0; i < 12; i++) b[i] = 8'h00;
        b[0] = op; b[2] = lba[31:24]; b[3] = lba[23:16]; b[4] = lba[15:8]; b[5] = lba[7:0];
        b[7] = nblk[15:8]; b[8] = nblk[7:0];
        for (int k = 0; k < 6; k++) wr(3'd0, {b[2*k+1], b[2*k]});
        rd(3'd7, d); check("R3 decode busy", d, 32'h00C0);
        bad = (op != 8'h28) || (!dma && lim < 16'd2);
        if (bad) begin
            wait_intr("R12 abort interrupt");
            rd(3'd7, d); check("R12 abort status", d, 32'h0041);
            rd(3'd1, d); check("R12 error register", d, 32'h0004);
            check("R9 cleared by status read", {31'b0, intrq}, 32'd0);
        end else if (nblk == 0) begin
            wait_intr("R13 zero count interrupt");
            rd(3'd7, d); check("R13 zero count status", d, 32'h0040);
        end else if (dma) begin
            check("R11 dma start pulse", {31'b0, dma_start}, 32'd1);
            rd(3'd7, d); check("R11 dma phase status", d, 32'h0048);
            check("R11 start is one cycle", {31'b0, dma_start}, 32'd0);
            repeat (3) @(negedge clk);
            check("R11 no interrupt before done", {31'b0, intrq}, 32'd0);
            dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
            check("R11 done interrupt", {31'b0, intrq}, 32'd1);
            rd(3'd7, d); check("R11 idle after done", d, 32'h0040);
        end else begin
            check("R4 start block", media_lba, lba);
            total = nblk * 2048; idx = 0;
            while (total > 0) begin
                burst = exp_burst(total, int'(lim));
                wait_intr("R7 burst interrupt");
                rd(3'd4, d); check("R6 burst count low", d, burst & 32'hFF);
                rd(3'd5, d); check("R6 burst count high", d, (burst >> 8) & 32'hFF);
                rd(3'd7, d); check("R7 burst status", d, 32'h0048);
                check("R9 cleared by status read", {31'b0, intrq}, 32'd0);
                for (int w = 0; w < (burst + 1) / 2; w++) begin
                    rd(3'd0, d);
                    check("R4 data word", d, mix(lba, 26'(idx)));
                    idx++;
                end
                total -= burst;
                if (total > 0) begin
                    if (collide) begin
                        rd(3'd7, d); check("R9 status on arm cycle", d, 32'h00C0);
                        check("R9 raise wins over clear", {31'b0, intrq}, 32'd1);
                    end else begin
                        rd(3'd0, d); check("R10 read while busy", d, 32'h0000);
                    end
                end
            end
            check("R8 completion interrupt", {31'b0, intrq}, 32'd1);
            rd(3'd7, d); check("R8 final status", d, 32'h0040);
            check("R8 interrupt cleared", {31'b0, intrq}, 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [15:0] lims [6];
        int unused_seed;
        unused_seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd7, d); check("R1 reset status", d, 32'h0040);
        check("R1 reset interrupt", {31'b0, intrq}, 32'd0);
        check("R1 reset dma strobe", {31'b0, dma_start}, 32'd0);
        rd(3'd4, d); check("R1 reset count low", d, 32'h0);
        rd(3'd5, d); check("R1 reset count high", d, 32'h0);
        wr(3'd7, 16'h00EC);
        rd(3'd7, d); check("R2 other command ignored", d, 32'h0040);
        check("R2 no interrupt for other command", {31'b0, intrq}, 32'd0);
        rd(3'd0, d); check("R10 idle data read", d, 32'h0000);
        // directed corners
        xact(8'h28, 32'h0000_0010, 2, 16'd5120, 1'b0, 1'b1);
        xact(8'h28, 32'h0102_0304, 3, 16'd5121, 1'b0, 1'b0);
        xact(8'h28, 32'h0000_0007, 2, 16'd4096, 1'b0, 1'b1);
        xact(8'h28, 32'hA5A5_0001, 1, 16'd3, 1'b0, 1'b1);
        xact(8'h28, 32'h0000_0002, 1, 16'd2, 1'b0, 1'b0);
        xact(8'h28, 32'h0000_0003, 1, 16'hFFFF, 1'b0, 1'b0);
        xact(8'h12, 32'h0, 1, 16'd512, 1'b0, 1'b0);
        xact(8'h28, 32'h0, 1, 16'd1, 1'b0, 1'b0);
        xact(8'h28, 32'h0, 1, 16'd0, 1'b0, 1'b0);
        xact(8'h28, 32'h0000_0044, 0, 16'd512, 1'b0, 1'b0);
        xact(8'h28, 32'h0000_0055, 4, 16'd0, 1'b1, 1'b0);
        xact(8'h28, 32'h0000_0066, 0, 16'd512, 1'b1, 1'b0);
        // constrained random
        for (int t = 0; t < 12; t++) begin
            lims[0] = 16'd512; lims[1] = 16'd1000; lims[2] = 16'd1001;
            lims[3] = 16'd5120; lims[4] = 16'hFFFF;
            lims[5] = 16'($urandom_range(2, 4096));
            xact(8'h28, $urandom, int'($urandom_range(1, 2)),
                 lims[$urandom_range(0, 5)], 1'b0, 1'($urandom_range(0, 1)));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule